// File: doc/BRIEF.md
# Multi-Cycle Register-Transfer Datapath

This block is the register-transfer datapath of a small 32-bit processor. It holds a bank of thirty-two 32-bit general registers, a program counter, an instruction register, a memory address register and a memory data register. It also has an arithmetic/logic unit and a separate +4 incrementer for the program counter. An external sequencer raises one transfer strobe per clock. Each strobe makes the datapath perform one transfer: select the fetch address, read memory, load the instruction, run a register or immediate operation, compute an effective address, move data between registers and the data register, write memory, branch, jump, or save a return link.

Every memory access goes through the address and data registers. The memory port is plain. The address comes from the address register and the write data from the data register. Read data must be valid in the same cycle as the read strobe, because the data register captures it at the closing clock edge. There is no back-pressure: a strobe always completes in its own cycle. The block decodes the instruction fields and the sign and zero state of the register named by the Rs1 field, and gives them to the sequencer.

Top module: `rtdp_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, instruction register, address register, data register and all 32 registers. After reset, mem_addr, mem_wdata and all field outputs read 0, rs1_zero is 1 and rs1_neg is 0.
- R2: The fetch takes three strobes. do_fetch_addr loads the address register from the PC. do_mem_read raises mem_rd in that cycle and loads the data register from mem_rdata. do_ir_load copies the data register into the instruction register and adds 4 to the PC in the same cycle.
- R3: The field outputs come from the instruction register: f_opcode is bits 31:26, f_rd is 25:21, f_rs1 is 20:16, f_rs2 is 15:11 and f_imm is 15:0. rs1_neg is bit 31 of the register selected by bits 20:16, and rs1_zero is 1 when that register equals 0.
- R4: do_alu_reg writes Rd = Rs1 op Rs2, with alu_op encoded as 0 add, 1 subtract, 2 multiply, 3 divide, 4 AND, 5 OR, 6 shift left, 7 logical shift right. Shifts use the low 5 bits of the second operand.
- R5: Multiply keeps the low 32 bits of the product. Divide is unsigned. A divisor of zero gives 32'hFFFFFFFF. Both finish in one cycle.
- R6: do_alu_imm writes Rd = Rs1 op sign-extended bits 15:0, using the same alu_op encoding. Shifts move by the low 5 bits of the constant and shift in zeros.
- R7: A load runs in three steps. do_addr_calc sets the address register to Rs1 + sign-extended bits 15:0. do_mem_read fills the data register. do_mdr_to_reg writes the data register into the register named by bits 25:21.
- R8: A store runs in three steps. do_addr_calc forms the address. do_mdr_from_reg copies the register named by bits 25:21 into the data register. do_mem_write raises mem_wr for one cycle, with the address and data registers on mem_addr and mem_wdata.
- R9: do_branch adds sign-extended bits 15:0 to the already-incremented PC.
- R10: do_jump_rel adds sign-extended bits 25:0 to the already-incremented PC.
- R11: do_jump_ind loads the PC with Rs1 + sign-extended bits 15:0.
- R12: do_link writes the current PC into R31.
- R13: At most one strobe is high in any cycle. In a cycle with no strobe, the PC, registers and bus outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_op | input | 3 | Operation for the register and immediate strobes |
| do_fetch_addr | input | 1 | Address register takes the PC |
| do_mem_read | input | 1 | Data register takes mem_rdata |
| do_ir_load | input | 1 | Instruction register takes the data register; PC advances by 4 |
| do_alu_reg | input | 1 | Rd takes Rs1 op Rs2 |
| do_alu_imm | input | 1 | Rd takes Rs1 op constant |
| do_addr_calc | input | 1 | Address register takes Rs1 plus constant |
| do_mdr_from_reg | input | 1 | Data register takes register at bits 25:21 |
| do_mem_write | input | 1 | Memory write of the data register at the address register |
| do_mdr_to_reg | input | 1 | Register at bits 25:21 takes the data register |
| do_branch | input | 1 | PC adds the 16-bit offset |
| do_jump_rel | input | 1 | PC adds the 26-bit offset |
| do_jump_ind | input | 1 | PC takes Rs1 plus the 16-bit offset |
| do_link | input | 1 | R31 takes the PC |
| mem_addr | output | 32 | Memory address (address register) |
| mem_wdata | output | 32 | Memory write data (data register) |
| mem_rdata | input | 32 | Memory read data, valid in the read strobe cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| f_opcode | output | 6 | Instruction bits 31:26 |
| f_rd | output | 5 | Instruction bits 25:21 |
| f_rs1 | output | 5 | Instruction bits 20:16 |
| f_rs2 | output | 5 | Instruction bits 15:11 |
| f_imm | output | 16 | Instruction bits 15:0 |
| rs1_neg | output | 1 | Sign of the register at bits 20:16 |
| rs1_zero | output | 1 | That register equals zero |

## Verification
The assertions assume the sequencer raises at most one strobe per clock and that reset is held through the first clock edge. Their checks on the address register, data register and PC are only valid under that assumption. The stimulus meets it by driving strobes from one bench task that sets a single bit per cycle and leaves an empty cycle between transfers. That task also supplies read data combinationally while a read strobe is high. Register numbers, constants and operand values are random from a fixed seed. Directed cases add a zero divisor, a full-width multiply, shifts of negative values, and branches both taken and not taken.

// File: rtl/rtdp_pkg.sv
package rtdp_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned REG_CNT = 32;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_DIV = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_SHL = 3'd6,
    OP_SHR = 3'd7
  } alu_op_e;
endpackage

// File: rtl/rtdp_regfile.sv
module rtdp_regfile #(
  parameter int unsigned W = rtdp_pkg::DATA_W,
  parameter int unsigned N = rtdp_pkg::REG_CNT,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] bank_q [N];

  // Three combinational read ports: operand A, operand B, store/target slot.
  assign rd1 = bank_q[ra1];
  assign rd2 = bank_q[ra2];
  assign rd3 = bank_q[ra3];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(N); i++) bank_q[i] <= '0;
    end else if (we) begin
      bank_q[wa] <= wd;
    end
  end
endmodule

// File: rtl/rtdp_alu.sv
module rtdp_alu
  import rtdp_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  localparam int unsigned SHW = $clog2(W)
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [SHW-1:0] amt;
  assign amt = b[SHW-1:0];

  always_comb begin
    unique case (op)
      OP_ADD: y = a + b;
      OP_SUB: y = a - b;
      OP_MUL: y = a * b;
      OP_DIV: y = (b == '0) ? '1 : a / b;
      OP_AND: y = a & b;
      OP_OR:  y = a | b;
      OP_SHL: y = a << amt;
      OP_SHR: y = a >> amt;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/rtdp_pc.sv
module rtdp_pc #(
  parameter int unsigned W = rtdp_pkg::DATA_W,
  parameter int unsigned STEP = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_en,
  input  logic         br_en,
  input  logic         jrel_en,
  input  logic         jind_en,
  input  logic [W-1:0] br_off,
  input  logic [W-1:0] jrel_off,
  input  logic [W-1:0] jind_tgt,
  output logic [W-1:0] pc_q
);
  localparam logic [W-1:0] STEP_W = W'(STEP);

  // Dedicated incrementer: never routed through the ALU.
  logic [W-1:0] pc_inc;
  assign pc_inc = pc_q + STEP_W;

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (inc_en)  pc_q <= pc_inc;
    else if (br_en)   pc_q <= pc_q + br_off;
    else if (jrel_en) pc_q <= pc_q + jrel_off;
    else if (jind_en) pc_q <= jind_tgt;
  end

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    inc_en |=> pc_q == $past(pc_q) + STEP_W);

  assert_pc_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !(inc_en || br_en || jrel_en || jind_en) |=> $stable(pc_q));
endmodule

// File: rtl/rtdp_core.sv
module rtdp_core
  import rtdp_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned NREG = REG_CNT,
  localparam int unsigned RAW = $clog2(NREG),
  localparam logic [RAW-1:0] LINK_IDX = RAW'(NREG - 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   alu_op,
  input  logic         do_fetch_addr,
  input  logic         do_mem_read,
  input  logic         do_ir_load,
  input  logic         do_alu_reg,
  input  logic         do_alu_imm,
  input  logic         do_addr_calc,
  input  logic         do_mdr_from_reg,
  input  logic         do_mem_write,
  input  logic         do_mdr_to_reg,
  input  logic         do_branch,
  input  logic         do_jump_rel,
  input  logic         do_jump_ind,
  input  logic         do_link,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic [5:0]   f_opcode,
  output logic [4:0]   f_rd,
  output logic [4:0]   f_rs1,
  output logic [4:0]   f_rs2,
  output logic [15:0]  f_imm,
  output logic         rs1_neg,
  output logic         rs1_zero
);
  logic [W-1:0] ir_q, mar_q, mdr_q, pc_q;
  logic [W-1:0] rs1_val, rs2_val, slot_val;
  logic [W-1:0] imm_sx, off_sx, alu_b, alu_y;
  logic         rf_we;
  logic [RAW-1:0] rf_wa;
  logic [W-1:0] rf_wd;
  alu_op_e      op_sel;

  // Field decode.
  assign f_opcode = ir_q[31:26];
  assign f_rd     = ir_q[25:21];
  assign f_rs1    = ir_q[20:16];
  assign f_rs2    = ir_q[15:11];
  assign f_imm    = ir_q[15:0];
  assign imm_sx   = {{(W-16){ir_q[15]}}, ir_q[15:0]};
  assign off_sx   = {{(W-26){ir_q[25]}}, ir_q[25:0]};

  rtdp_regfile #(.W(W), .N(NREG)) u_rf (
    .clk (clk), .rst (rst),
    .ra1 (ir_q[20:16]), .ra2 (ir_q[15:11]), .ra3 (ir_q[25:21]),
    .rd1 (rs1_val), .rd2 (rs2_val), .rd3 (slot_val),
    .we  (rf_we), .wa (rf_wa), .wd (rf_wd)
  );

  // ALU is shared with effective-address and indirect-target computation.
  assign op_sel = (do_alu_reg || do_alu_imm) ? alu_op_e'(alu_op) : OP_ADD;
  assign alu_b  = do_alu_reg ? rs2_val : imm_sx;

  rtdp_alu #(.W(W)) u_alu (.op(op_sel), .a(rs1_val), .b(alu_b), .y(alu_y));

  rtdp_pc #(.W(W), .STEP(4)) u_pc (
    .clk (clk), .rst (rst),
    .inc_en (do_ir_load), .br_en (do_branch),
    .jrel_en (do_jump_rel), .jind_en (do_jump_ind),
    .br_off (imm_sx), .jrel_off (off_sx), .jind_tgt (alu_y),
    .pc_q (pc_q)
  );

  // Register write port selection.
  always_comb begin
    rf_we = do_alu_reg || do_alu_imm || do_mdr_to_reg || do_link;
    rf_wa = do_link ? LINK_IDX : ir_q[25:21];
    if (do_link)            rf_wd = pc_q;
    else if (do_mdr_to_reg) rf_wd = mdr_q;
    else                    rf_wd = alu_y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      if (do_ir_load) ir_q <= mdr_q;
      if (do_fetch_addr)     mar_q <= pc_q;
      else if (do_addr_calc) mar_q <= alu_y;
      if (do_mem_read)           mdr_q <= mem_rdata;
      else if (do_mdr_from_reg)  mdr_q <= slot_val;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_rd    = do_mem_read;
  assign mem_wr    = do_mem_write;
  assign rs1_neg   = rs1_val[W-1];
  assign rs1_zero  = (rs1_val == '0);

  assert_one_strobe_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_fetch_addr, do_mem_read, do_ir_load, do_alu_reg, do_alu_imm,
              do_addr_calc, do_mdr_from_reg, do_mem_write, do_mdr_to_reg,
              do_branch, do_jump_rel, do_jump_ind, do_link}));

  assert_mar_from_pc_R2: assert property (@(posedge clk) disable iff (rst)
    do_fetch_addr |=> mem_addr == $past(pc_q));

  assert_mdr_capture_R2: assert property (@(posedge clk) disable iff (rst)
    do_mem_read |=> mem_wdata == $past(mem_rdata));

  assert_ea_R7: assert property (@(posedge clk) disable iff (rst)
    do_addr_calc |=> mem_addr == $past(rs1_val) + $past(imm_sx));

  assert_bus_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !(do_fetch_addr || do_addr_calc || do_mem_read || do_mdr_from_reg)
      |=> $stable(mem_addr) && $stable(mem_wdata));
endmodule

// File: tb/test_rtdp_core.sv
module test_rtdp_core;
  localparam int CLK_PERIOD = 10;
  localparam int S_FA = 0, S_MR = 1, S_IR = 2, S_AR = 3, S_AI = 4, S_AC = 5,
                 S_MFR = 6, S_MW = 7, S_MTR = 8, S_BR = 9, S_JR = 10,
                 S_JI = 11, S_LK = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic [12:0] st = '0;
  logic [2:0]  aop = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, rs1_neg, rs1_zero;
  logic [5:0]  f_opcode;
  logic [4:0]  f_rd, f_rs1, f_rs2;
  logic [15:0] f_imm;
  logic        ovr_en = 1'b0;
  logic [31:0] ovr_word = '0;
  logic [31:0] data_mem [64];
  logic [31:0] rm [32];
  logic [31:0] pc_m;
  logic        seen_rd, seen_wr;
  int          nvec = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtdp_core i_rtdp_core (
    .clk(clk), .rst(rst), .alu_op(aop),
    .do_fetch_addr(st[S_FA]), .do_mem_read(st[S_MR]), .do_ir_load(st[S_IR]),
    .do_alu_reg(st[S_AR]), .do_alu_imm(st[S_AI]), .do_addr_calc(st[S_AC]),
    .do_mdr_from_reg(st[S_MFR]), .do_mem_write(st[S_MW]),
    .do_mdr_to_reg(st[S_MTR]), .do_branch(st[S_BR]), .do_jump_rel(st[S_JR]),
    .do_jump_ind(st[S_JI]), .do_link(st[S_LK]),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr),
    .f_opcode(f_opcode), .f_rd(f_rd), .f_rs1(f_rs1), .f_rs2(f_rs2),
    .f_imm(f_imm), .rs1_neg(rs1_neg), .rs1_zero(rs1_zero)
  );

  // Bench memory: combinational read, optional override word for fetches.
  assign mem_rdata = ovr_en ? ovr_word : data_mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_wr) data_mem[mem_addr[7:2]] <= mem_wdata;

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic logic [31:0] sx26(input logic [25:0] v);
    return {{6{v[25]}}, v};
  endfunction
  function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a * b;
      3'd3: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      3'd4: return a & b;
      3'd5: return a | b;
      3'd6: return a << b[4:0];
      default: return a >> b[4:0];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int idx);
    @(negedge clk);
    st = '0;
    st[idx] = 1'b1;
    #1;
    seen_rd = mem_rd;
    seen_wr = mem_wr;
    @(negedge clk);
    st = '0;
  endtask

  task automatic fetch(input logic [31:0] w, input string pctag);
    cyc(S_FA);
    chk(pctag, mem_addr, pc_m);
    ovr_en = 1'b1; ovr_word = w;
    cyc(S_MR);
    ovr_en = 1'b0;
    chk("R2 read strobe", {31'b0, seen_rd}, 32'd1);
    chk("R2 mdr capture", mem_wdata, w);
    cyc(S_IR);
    pc_m = pc_m + 4;
    chk("R3 fields", {f_opcode, f_rd, f_rs1, f_imm}, w);
    chk("R3 rs2 field", {27'b0, f_rs2}, {27'b0, w[15:11]});
    chk("R3 rs1 flags", {30'b0, rs1_neg, rs1_zero},
        {30'b0, rm[w[20:16]][31], rm[w[20:16]] == 32'd0});
  endtask

  task automatic rdreg(input logic [4:0] r, output logic [31:0] v);
    fetch({6'h3F, r, 21'h0}, "R2 pc");
    cyc(S_MFR);
    v = mem_wdata;
  endtask

  task automatic setreg(input logic [4:0] r, input logic [31:0] v);
    fetch({6'h10, r, 5'd0, 16'h0000}, "R2 pc");
    cyc(S_AC);
    ovr_en = 1'b1; ovr_word = v;
    cyc(S_MR);
    ovr_en = 1'b0;
    cyc(S_MTR);
    rm[r] = v;
  endtask

  task automatic do_rr(input logic [2:0] op, input logic [4:0] rd, input logic [4:0] a, input logic [4:0] b, input string tag);
    logic [31:0] got;
    logic [31:0] exp;
    exp = ref_alu(op, rm[a], rm[b]);
    fetch({6'h01, rd, a, b, 11'h0}, "R2 pc");
    aop = op;
    cyc(S_AR);
    rm[rd] = exp;
    rdreg(rd, got);
    chk(tag, got, exp);
  endtask

  task automatic do_ri(input logic [2:0] op, input logic [4:0] rd, input logic [4:0] a, input logic [15:0] k, input string tag);
    logic [31:0] got;
    logic [31:0] exp;
    exp = ref_alu(op, rm[a], sx16(k));
    fetch({6'h02, rd, a, k}, "R2 pc");
    aop = op;
    cyc(S_AI);
    rm[rd] = exp;
    rdreg(rd, got);
    chk(tag, got, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nvec, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v, ea, expv;
    logic [4:0] rb, rs, rd;
    logic [15:0] k;
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 32; i++) rm[i] = '0;
    pc_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state visible at the ports.
    chk("R1 mem_addr", mem_addr, 32'd0);
    chk("R1 mem_wdata", mem_wdata, 32'd0);
    chk("R1 fields", {f_opcode, f_rd, f_rs1, f_imm}, 32'd0);
    chk("R1 flags", {30'b0, rs1_neg, rs1_zero}, 32'd1);
    rdreg(5'd17, v); chk("R1 reg17 cleared", v, 32'd0);
    rdreg(5'd31, v); chk("R1 reg31 cleared", v, 32'd0);

    // Seed registers 1..30 with random values, some zero and negative.
    for (int r = 1; r < 31; r++) begin
      v = $urandom;
      if (r % 7 == 0) v = 32'd0;
      if (r % 5 == 0) v[31] = 1'b1;
      setreg(5'(r), v);
    end
    for (int r = 1; r < 31; r += 6) begin
      rdreg(5'(r), v);
      chk("R7 load via override", v, rm[r]);
    end

    // R4: register-register random operations.
    for (int n = 0; n < 40; n++) begin
      rd = 5'(1 + $urandom % 30);
      do_rr(3'($urandom % 8), rd, 5'($urandom % 32), 5'($urandom % 32), "R4 reg-reg op");
    end
    // R5: directed multiply and divide corner cases.
    setreg(5'd3, 32'hFFFF_FFFF);
    setreg(5'd4, 32'h8000_0003);
    do_rr(3'd2, 5'd6, 5'd3, 5'd4, "R5 mul low word");
    do_rr(3'd3, 5'd6, 5'd4, 5'd0, "R5 div by zero reg");
    do_rr(3'd3, 5'd8, 5'd3, 5'd4, "R5 unsigned div");
    do_ri(3'd3, 5'd9, 5'd3, 16'h0000, "R5 div by zero imm");

    // R6: register-constant random operations plus shift corners.
    for (int n = 0; n < 40; n++) begin
      rd = 5'(1 + $urandom % 30);
      do_ri(3'($urandom % 8), rd, 5'($urandom % 32), 16'($urandom), "R6 reg-imm op");
    end
    do_ri(3'd7, 5'd10, 5'd4, 16'h0004, "R6 logical shift right of negative");
    do_ri(3'd6, 5'd11, 5'd4, 16'h001F, "R6 shift left by 31");
    do_ri(3'd4, 5'd12, 5'd3, 16'h8001, "R6 and with sign-extended imm");
    do_ri(3'd1, 5'd13, 5'd0, 16'h0001, "R6 subtract imm");

    // R8/R7: stores followed by loads through real memory.
    setreg(5'd20, 32'h0000_0100);
    for (int n = 0; n < 8; n++) begin
      rs = 5'(1 + $urandom % 30);
      k = 16'(($urandom % 32) * 4 - 64);
      ea = rm[20] + sx16(k);
      fetch({6'h11, rs, 5'd20, k}, "R2 pc");
      cyc(S_AC);
      chk("R8 store address", mem_addr, ea);
      cyc(S_MFR);
      cyc(S_MW);
      chk("R8 write strobe", {31'b0, seen_wr}, 32'd1);
      chk("R8 stored word", data_mem[ea[7:2]], rm[rs]);
      rd = 5'(1 + $urandom % 19);
      expv = rm[rs];
      fetch({6'h10, rd, 5'd20, k}, "R2 pc");
      cyc(S_AC);
      cyc(S_MR);
      cyc(S_MTR);
      rm[rd] = expv;
      rdreg(rd, v);
      chk("R7 load from memory", v, expv);
    end

    // R9: branches taken and not taken; next fetch address checks PC.
    setreg(5'd21, 32'd0);
    setreg(5'd22, 32'hFFFF_FFF0);
    setreg(5'd23, 32'd5);
    for (int n = 0; n < 16; n++) begin
      int c;
      logic take;
      rs = 5'(21 + $urandom % 3);
      c = int'($urandom % 4);
      k = 16'(($urandom % 16) * 4 - 32);
      case (c)
        0: take = rm[rs][31];
        1: take = !rm[rs][31] && (rm[rs] != 0);
        2: take = (rm[rs] == 0);
        default: take = (rm[rs] != 0);
      endcase
      fetch({6'h20, 5'd0, rs, k}, "R2 pc");
      if (take) begin
        cyc(S_BR);
        pc_m = pc_m + sx16(k);
      end
      fetch({6'h3F, 5'd0, 5'd0, 16'h0}, "R9 branch target");
    end

    // R10: PC-relative jump, negative and positive offsets.
    fetch({6'h30, 26'h3FF_FFF0}, "R2 pc");
    cyc(S_JR); pc_m = pc_m + sx26(26'h3FF_FFF0);
    fetch({6'h30, 26'h000_0104}, "R10 jump rel back");
    cyc(S_JR); pc_m = pc_m + sx26(26'h000_0104);
    fetch({6'h3F, 26'h0}, "R10 jump rel fwd");

    // R11: register-indirect jump.
    setreg(5'd24, 32'h0000_4000);
    fetch({6'h31, 5'd0, 5'd24, 16'hFFFC}, "R2 pc");
    cyc(S_JI); pc_m = rm[24] + sx16(16'hFFFC);
    fetch({6'h3F, 26'h0}, "R11 jump indirect");

    // R12: jump and link saves the incremented PC into R31.
    fetch({6'h32, 26'h000_0040}, "R2 pc");
    cyc(S_LK); rm[31] = pc_m;
    cyc(S_JR); pc_m = pc_m + 32'h40;
    expv = rm[31];
    rdreg(5'd31, v);
    chk("R12 link value", v, expv);

    // R13: idle cycles change nothing.
    rdreg(5'd23, v);
    ea = mem_addr;
    repeat (6) @(negedge clk);
    chk("R13 bus address held", mem_addr, ea);
    chk("R13 bus data held", mem_wdata, v);
    fetch({6'h3F, 5'd23, 21'h0}, "R13 pc held");
    cyc(S_MFR);
    chk("R13 register held", mem_wdata, rm[23]);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule